// File: doc/BRIEF.md
# Pseudo-Static RAM Host Controller

This block sits between a synchronous host and an asynchronous 128K x 8 pseudo-static RAM. The RAM's cells need refreshing, but its pins look like an SRAM's. The host sees a valid/ready request port and a one-cycle read-response strobe. The memory side carries a 17-bit address, an 8-bit data path and four active-low strobes: chip enable, output enable, write enable and refresh. The 8-bit data path is split into output data, an output-enable and input data, so an I/O cell at the chip edge can form the tri-state bus.

Every timing figure is a clock-cycle count set by a parameter. The defaults assume a 4 ns clock. After reset, the controller keeps the memory deselected for the power-up wait. It then issues a burst of dummy chip-enable cycles, and only after that does it open the host port.

From then on it serves reads, writes and read-modify-writes. A separate scheduler raises a refresh request at a fixed interval. A pending refresh is served before any new host request, by a refresh-strobe pulse and then a refresh precharge. While the refresh is pending or running, host requests are held off by keeping ready low.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is applied, all four memory strobes are high, the data output-enable is low and host ready is low.
- R2: After reset, chip enable stays high for at least INIT_CYC cycles. Exactly DUMMY_CNT chip-enable pulses then follow, with output enable, write enable and refresh all high, before host ready first rises. No read response is produced before that point.
- R3: A request with op 2'b00 is a read. Chip enable is low for T_CE cycles with output enable low throughout. The data on the memory input in the last low cycle is returned on the response data with a one-cycle response-valid pulse.
- R4: The memory address changes only while chip enable is high. It is already stable in the cycle before chip enable falls and does not change while chip enable is low.
- R5: A request with op 2'b01 is a write. Chip enable is low for T_CE cycles. Write enable is low for the first T_CE-1 of those cycles and rises while chip enable is still low. The host write data is driven, with the data output-enable high, whenever write enable rises.
- R6: A request with op 2'b10 or 2'b11 is a read-modify-write inside a single chip-enable pulse of T_RMW cycles. The old data is returned as in R3 and the new data is then written. The data output-enable rises only after output enable has been high for at least one cycle.
- R7: Every chip-enable low pulse lasts exactly T_CE or T_RMW cycles. Chip enable stays high for at least T_P cycles between pulses.
- R8: After initialisation, the refresh strobe pulses low for exactly T_FAP cycles about once every REF_INTERVAL cycles, and only while chip enable is high. The memory is then left untouched for at least max(T_FP, T_FC-T_FAP) cycles.
- R9: A pending refresh wins over a host request. Ready is low while the refresh strobe is low and until its precharge has finished, and the stalled request is then accepted and completed.
- R10: The data output-enable is high only inside the write phase of an access: chip enable is low and output enable is high. Write enable is never low without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Controller can accept a request this cycle |
| host_op | input | 2 | 00 read, 01 write, 1x read-modify-write |
| host_addr | input | 17 | Word address of the request |
| host_wdata | input | 8 | Write data (write and read-modify-write) |
| host_rvalid | output | 1 | One-cycle pulse: read data valid |
| host_rdata | output | 8 | Read data |
| ram_addr | output | 17 | Memory address |
| ram_dq_out | output | 8 | Data toward the memory |
| ram_dq_oe | output | 1 | Enable for the data output driver |
| ram_dq_in | input | 8 | Data from the memory |
| ram_ce_n | output | 1 | Chip enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_we_n | output | 1 | Read/write strobe, low writes |
| ram_rfsh_n | output | 1 | Refresh strobe, active low |

## Verification
The two functions that can land in the same cycle are a refresh tick and a host request arriving in the idle state.

The bench provokes this collision in two ways. It streams hundreds of back-to-back requests across many refresh intervals, and it raises requests at the moment the refresh strobe is seen low.

Each collision is judged on four points: ready must stay low through the refresh and its precharge, no chip-enable pulse may overlap or crowd the refresh window, refresh spacing must stay within a bounded window around REF_INTERVAL, and every delayed read must still return the data last written.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_PRE,
        ST_RF_PULSE,
        ST_RF_PRE
    } seq_st_e;

    typedef enum logic [1:0] {
        OP_READ,
        OP_WRITE,
        OP_RMW,
        OP_DUMMY
    } acc_op_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic rfsh_n;
        logic dq_oe;
    } strobe_t;

endpackage

// File: rtl/psram_refresh_sched.sv
module psram_refresh_sched #(
    parameter int REF_INTERVAL = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ack,
    output logic pending
);

    localparam int RW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

    typedef struct packed {
        logic [RW-1:0] cnt;
        logic          pending;
    } sched_t;

    sched_t s_d, s_q;
    logic   tick;

    always_comb begin
        s_d  = s_q;
        tick = en && (s_q.cnt == RW'(REF_INTERVAL - 1));
        if (!en) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        if (tick) begin
            s_d.pending = 1'b1;
        end else if (ack) begin
            s_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pending = s_q.pending;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pending && !ack) |-> !tick); // R8
    AST_ACK_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> s_q.pending); // R9

endmodule

// File: rtl/psram_seq.sv
module psram_seq
    import psram_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int INIT_CYC  = 25000,
    parameter int DUMMY_CNT = 8,
    parameter int T_AS      = 1,
    parameter int T_CE      = 15,
    parameter int T_P       = 10,
    parameter int T_FAP     = 8,
    parameter int T_FP      = 8,
    parameter int T_FC      = 25,
    parameter int T_RMW     = 42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              ref_pending,
    output logic              ref_ack,
    output logic              init_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_rfsh_n
);

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int RMW_WR     = T_RMW - T_CE;
    localparam int RF_PRE_CYC = max2(T_FP, T_FC - T_FAP);
    localparam int CNT_MAX    = max2(max2(INIT_CYC, T_RMW), max2(RF_PRE_CYC, max2(T_P, T_FAP)));
    localparam int CW         = $clog2(CNT_MAX + 1);
    localparam int DW         = (DUMMY_CNT > 1) ? $clog2(DUMMY_CNT + 1) : 1;

    typedef struct packed {
        seq_st_e           st;
        logic              wr_ph;
        acc_op_e           op;
        logic [CW-1:0]     cnt;
        logic [DW-1:0]     dummy;
        logic              init_done;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rsp_valid;
    } seq_t;

    seq_t    s_d, s_q;
    strobe_t strb_d, strb_q;

    // Strobe levels that belong to a given sequencer state.
    function automatic strobe_t decode(input seq_t s);
        strobe_t o;
        logic    act, wr, gap;
        act      = (s.st == ST_ACTIVE);
        wr       = act && s.wr_ph;
        gap      = (s.op == OP_RMW) && (s.cnt == CW'(RMW_WR - 1));
        o.ce_n   = !act;
        o.rfsh_n = (s.st != ST_RF_PULSE);
        o.oe_n   = !(act && !s.wr_ph && (s.op != OP_DUMMY));
        o.dq_oe  = wr && !gap;
        o.we_n   = !(wr && !gap && (s.cnt != '0));
        return o;
    endfunction

    assign ready = s_q.init_done && (s_q.st == ST_IDLE) && !ref_pending;

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        ref_ack       = 1'b0;
        case (s_q.st)
            ST_INIT: begin
                if (s_q.cnt == '0) begin
                    s_d.st    = ST_SETUP;
                    s_d.op    = OP_DUMMY;
                    s_d.addr  = '0;
                    s_d.cnt   = CW'(T_AS - 1);
                    s_d.dummy = DW'(DUMMY_CNT - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_IDLE: begin
                if (ref_pending) begin
                    ref_ack = 1'b1;
                    s_d.st  = ST_RF_PULSE;
                    s_d.cnt = CW'(T_FAP - 1);
                end else if (req_valid && s_q.init_done) begin
                    case (req_op)
                        2'b00:   s_d.op = OP_READ;
                        2'b01:   s_d.op = OP_WRITE;
                        default: s_d.op = OP_RMW;
                    endcase
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    s_d.st    = ST_SETUP;
                    s_d.cnt   = CW'(T_AS - 1);
                end
            end
            ST_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.st    = ST_ACTIVE;
                    s_d.wr_ph = (s_q.op == OP_WRITE);
                    s_d.cnt   = CW'(T_CE - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (!s_q.wr_ph) begin
                    if (s_q.op != OP_DUMMY) begin
                        s_d.rdata     = mem_dq_in;
                        s_d.rsp_valid = 1'b1;
                    end
                    if (s_q.op == OP_RMW) begin
                        s_d.wr_ph = 1'b1;
                        s_d.cnt   = CW'(RMW_WR - 1);
                    end else begin
                        s_d.st  = ST_PRE;
                        s_d.cnt = CW'(T_P - 1);
                    end
                end else begin
                    s_d.st  = ST_PRE;
                    s_d.cnt = CW'(T_P - 1);
                end
            end
            ST_PRE: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if ((s_q.op == OP_DUMMY) && (s_q.dummy != '0)) begin
                    s_d.dummy = s_q.dummy - 1'b1;
                    s_d.st    = ST_SETUP;
                    s_d.cnt   = CW'(T_AS - 1);
                end else begin
                    if (s_q.op == OP_DUMMY) begin
                        s_d.init_done = 1'b1;
                    end
                    s_d.st = ST_IDLE;
                end
            end
            ST_RF_PULSE: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_RF_PRE;
                    s_d.cnt = CW'(RF_PRE_CYC - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RF_PRE: begin
                if (s_q.cnt == '0) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        strb_d = decode(s_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.st     <= ST_INIT;
            s_q.cnt    <= CW'(INIT_CYC - 1);
            strb_q     <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, rfsh_n: 1'b1, dq_oe: 1'b0};
        end else begin
            s_q    <= s_d;
            strb_q <= strb_d;
        end
    end

    assign init_done  = s_q.init_done;
    assign rsp_valid  = s_q.rsp_valid;
    assign rsp_rdata  = s_q.rdata;
    assign mem_addr   = s_q.addr;
    assign mem_dq_out = s_q.wdata;
    assign mem_dq_oe  = strb_q.dq_oe;
    assign mem_ce_n   = strb_q.ce_n;
    assign mem_oe_n   = strb_q.oe_n;
    assign mem_we_n   = strb_q.we_n;
    assign mem_rfsh_n = strb_q.rfsh_n;

    // Checking aid: cycles the chip enable has held its present level.
    logic [15:0] ce_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_run <= '0;
        end else if (strb_d.ce_n != strb_q.ce_n) begin
            ce_run <= 16'd1;
        end else if (ce_run != 16'hFFFF) begin
            ce_run <= ce_run + 16'd1;
        end
    end

    AST_CE_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_q.ce_n && strb_d.ce_n) |-> (ce_run >= 16'(T_CE))); // R7
    AST_CE_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_q.ce_n && !strb_d.ce_n) |-> (ce_run >= 16'(T_P))); // R7
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_q.ce_n |-> $stable(s_q.addr)); // R4
    AST_WE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_q.we_n) |-> (strb_q.dq_oe && !strb_q.ce_n)); // R5
    AST_RFSH_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_q.rfsh_n |-> (strb_q.ce_n && $past(strb_q.ce_n))); // R8
    AST_NO_ACCEPT_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_q.rfsh_n |-> !ready); // R9
    AST_DQ_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        strb_q.dq_oe |-> (strb_q.oe_n && !strb_q.ce_n)); // R10
    AST_RSP_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rsp_valid |-> s_q.init_done); // R2

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl #(
    parameter int ADDR_W       = 17,
    parameter int DATA_W       = 8,
    parameter int INIT_CYC     = 25000,
    parameter int DUMMY_CNT    = 8,
    parameter int REF_INTERVAL = 3900,
    parameter int T_AS         = 1,
    parameter int T_CE         = 15,
    parameter int T_P          = 10,
    parameter int T_FAP        = 8,
    parameter int T_FP         = 8,
    parameter int T_FC         = 25,
    parameter int T_RMW        = 42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic [1:0]        host_op,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic              ram_ce_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic              ram_rfsh_n
);

    logic ref_pending;
    logic ref_ack;
    logic init_done;

    psram_refresh_sched #(
        .REF_INTERVAL(REF_INTERVAL)
    ) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (init_done),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    psram_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .INIT_CYC  (INIT_CYC),
        .DUMMY_CNT (DUMMY_CNT),
        .T_AS      (T_AS),
        .T_CE      (T_CE),
        .T_P       (T_P),
        .T_FAP     (T_FAP),
        .T_FP      (T_FP),
        .T_FC      (T_FC),
        .T_RMW     (T_RMW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (host_valid),
        .req_op      (host_op),
        .req_addr    (host_addr),
        .req_wdata   (host_wdata),
        .ready       (host_ready),
        .rsp_valid   (host_rvalid),
        .rsp_rdata   (host_rdata),
        .ref_pending (ref_pending),
        .ref_ack     (ref_ack),
        .init_done   (init_done),
        .mem_addr    (ram_addr),
        .mem_dq_out  (ram_dq_out),
        .mem_dq_oe   (ram_dq_oe),
        .mem_dq_in   (ram_dq_in),
        .mem_ce_n    (ram_ce_n),
        .mem_oe_n    (ram_oe_n),
        .mem_we_n    (ram_we_n),
        .mem_rfsh_n  (ram_rfsh_n)
    );

endmodule

// File: tb/test_psram_ctrl.sv
module test_psram_ctrl;

    localparam int INIT_CYC     = 60;
    localparam int DUMMY_CNT    = 8;
    localparam int REF_INTERVAL = 400;
    localparam int T_AS         = 1;
    localparam int T_CE         = 15;
    localparam int T_P          = 10;
    localparam int T_FAP        = 8;
    localparam int T_FP         = 8;
    localparam int T_FC         = 25;
    localparam int T_RMW        = 42;
    localparam int RF_PRE       = (T_FP > T_FC - T_FAP) ? T_FP : T_FC - T_FAP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic [1:0]  host_op = 2'b00;
    logic [16:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_rvalid;
    logic [7:0]  host_rdata;
    logic [16:0] ram_addr;
    logic [7:0]  ram_dq_out;
    logic        ram_dq_oe;
    logic [7:0]  ram_dq_in;
    logic        ram_ce_n, ram_oe_n, ram_we_n, ram_rfsh_n;

    always #2 clk = ~clk;

    psram_ctrl #(
        .INIT_CYC(INIT_CYC), .DUMMY_CNT(DUMMY_CNT), .REF_INTERVAL(REF_INTERVAL),
        .T_AS(T_AS), .T_CE(T_CE), .T_P(T_P), .T_FAP(T_FAP), .T_FP(T_FP),
        .T_FC(T_FC), .T_RMW(T_RMW)
    ) i_psram_ctrl (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .host_op(host_op), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata), .ram_addr(ram_addr),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in),
        .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
        .ram_rfsh_n(ram_rfsh_n)
    );

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural memory device and host-side shadow.
    logic [7:0]  dev_mem [int];
    logic [7:0]  shadow  [int];
    logic [7:0]  exp_q[$];
    logic [16:0] addr_lat = '0;
    logic [7:0]  rd_val = 8'h00;

    assign ram_dq_in = (!ram_ce_n && !ram_oe_n && ram_we_n) ? rd_val : 8'hEE;

    int  cyc = 0;
    int  ce_run = 0, rf_run = 0;
    bit  p_ce = 1'b1, p_oe = 1'b1, p_we = 1'b1, p_rf = 1'b1, p_dqoe = 1'b0;
    logic [16:0] p_addr = '0;
    bit  seen_ready = 1'b0, first_fall = 1'b1, rf_seen = 1'b0, rf_fall_seen = 1'b0;
    int  init_pulses = 0, init_cyc = 0, rf_rise_cyc = 0, rf_fall_cyc = 0, rf_count = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!seen_ready) begin
                check(ram_oe_n && ram_we_n && ram_rfsh_n && !ram_dq_oe && !host_rvalid,
                      "R2 init strobes", {ram_oe_n, ram_we_n, ram_rfsh_n, ram_dq_oe}, 4'b1110);
            end
            // chip enable falling
            if (p_ce && !ram_ce_n) begin
                if (first_fall) begin
                    check(ce_run >= INIT_CYC, "R2 power-up deselect", ce_run, INIT_CYC);
                    first_fall = 1'b0;
                end else begin
                    check(ce_run >= T_P, "R7 precharge", ce_run, T_P);
                end
                check(ram_addr == p_addr, "R4 address setup", int'(ram_addr), int'(p_addr));
                if (rf_seen) check(cyc - rf_rise_cyc >= RF_PRE, "R8 refresh precharge before access",
                                   cyc - rf_rise_cyc, RF_PRE);
                if (!seen_ready) init_pulses++;
                addr_lat = ram_addr;
                rd_val = dev_mem.exists(int'(ram_addr)) ? dev_mem[int'(ram_addr)] : 8'h00;
            end
            if (!p_ce && !ram_ce_n) check(ram_addr == addr_lat, "R4 address hold", int'(ram_addr), int'(addr_lat));
            // chip enable rising
            if (!p_ce && ram_ce_n) begin
                check(ce_run == T_CE || ce_run == T_RMW, "R7 pulse width", ce_run, T_CE);
            end
            // write strobe rising: data captured
            if (!p_we && ram_we_n) begin
                check(!ram_ce_n && ram_dq_oe, "R5 data held at write edge", {ram_ce_n, ram_dq_oe}, 2'b01);
                dev_mem[int'(addr_lat)] = ram_dq_out;
                rd_val = ram_dq_out;
            end
            // refresh strobe
            if (p_rf && !ram_rfsh_n) begin
                check(ram_ce_n && p_ce, "R8 refresh while deselected", {p_ce, ram_ce_n}, 2'b11);
                if (rf_seen) check(cyc - rf_rise_cyc >= RF_PRE, "R8 refresh spacing", cyc - rf_rise_cyc, RF_PRE);
                if (rf_fall_seen) check((cyc - rf_fall_cyc >= REF_INTERVAL - 64) && (cyc - rf_fall_cyc <= REF_INTERVAL + 64),
                                        "R8 refresh interval", cyc - rf_fall_cyc, REF_INTERVAL);
                rf_fall_seen = 1'b1;
                rf_fall_cyc = cyc;
                rf_count++;
            end
            if (!p_rf && ram_rfsh_n) begin
                check(rf_run == T_FAP, "R8 refresh pulse width", rf_run, T_FAP);
                rf_seen = 1'b1;
                rf_rise_cyc = cyc;
            end
            if (!ram_rfsh_n) check(!host_ready, "R9 ready low during refresh", int'(host_ready), 0);
            if (host_ready && rf_seen) check(ram_rfsh_n && (cyc - rf_rise_cyc >= RF_PRE),
                                             "R9 ready after refresh precharge", cyc - rf_rise_cyc, RF_PRE);
            if (ram_dq_oe) check(ram_oe_n && !ram_ce_n, "R10 driver only in write phase",
                                 {ram_oe_n, ram_ce_n}, 2'b10);
            if (!ram_we_n) check(ram_dq_oe, "R10 write strobe without driver", int'(ram_dq_oe), 1);
            if (ram_dq_oe && !p_dqoe) check(p_oe, "R6 turnaround before drive", int'(p_oe), 1);
            if (host_rvalid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected response", int'(host_rdata), -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(host_rdata == e, "R3/R6 read data", int'(host_rdata), int'(e));
                end
            end
            if (host_ready && !seen_ready) begin
                seen_ready = 1'b1;
                init_cyc = cyc;
                check(init_pulses == DUMMY_CNT, "R2 dummy cycle count", init_pulses, DUMMY_CNT);
            end
            ce_run = (ram_ce_n == p_ce) ? ce_run + 1 : 1;
            rf_run = (ram_rfsh_n == p_rf) ? rf_run + 1 : 1;
        end
        p_ce = ram_ce_n; p_oe = ram_oe_n; p_we = ram_we_n; p_rf = ram_rfsh_n;
        p_dqoe = ram_dq_oe; p_addr = ram_addr;
    end

    task automatic host_req(input logic [1:0] op, input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        host_valid = 1'b1;
        host_op = op;
        host_addr = a;
        host_wdata = d;
        while (!host_ready) @(negedge clk);
        if (op == 2'b00) begin
            exp_q.push_back(shadow[int'(a)]);
        end else if (op == 2'b01) begin
            shadow[int'(a)] = d;
        end else begin
            exp_q.push_back(shadow[int'(a)]);
            shadow[int'(a)] = d;
        end
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    function automatic logic [16:0] pick(input int i);
        if (i == 0) return 17'h00000;
        if (i == 1) return 17'h1FFFF;
        return 17'((i * 4099 + 7) & 17'h1FFFF);
    endfunction

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ram_ce_n && ram_oe_n && ram_we_n && ram_rfsh_n, "R1 strobes in reset",
              {ram_ce_n, ram_oe_n, ram_we_n, ram_rfsh_n}, 4'b1111);
        check(!ram_dq_oe, "R1 driver off in reset", int'(ram_dq_oe), 0);
        check(!host_ready && !host_rvalid, "R1 host port closed in reset", {host_ready, host_rvalid}, 0);
        rst_n = 1'b1;
        while (!host_ready) @(negedge clk);

        // R5: fill a spread of addresses, including both ends
        for (int i = 0; i < 32; i++) host_req(2'b01, pick(i), 8'((i * 37) ^ 8'h5A));
        // R3: read everything back
        for (int i = 0; i < 32; i++) host_req(2'b00, pick(i), 8'h00);
        // R6: read-modify-write with both encodings, then confirm
        for (int i = 0; i < 8; i++) host_req((i % 2 == 0) ? 2'b10 : 2'b11, pick(i), 8'(8'hC3 ^ i));
        for (int i = 0; i < 8; i++) host_req(2'b00, pick(i), 8'h00);
        // R9: raise requests while refresh strobe is low
        for (int k = 0; k < 3; k++) begin
            while (ram_rfsh_n) @(negedge clk);
            host_req(2'b00, pick(k + 3), 8'h00);
        end
        // R8/R9: long mixed stream spanning many refresh intervals
        lfsr = 16'hACE1;
        for (int n = 0; n < 200; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            host_req(lfsr[1:0], pick(int'(lfsr[6:2])), lfsr[15:8]);
        end
        for (int i = 0; i < 32; i++) host_req(2'b00, pick(i), 8'h00);
        // R8: idle period, refresh continues on its own
        repeat (3 * REF_INTERVAL) @(negedge clk);
        check(exp_q.size() == 0, "R3 all responses returned", exp_q.size(), 0);
        begin
            int exp_rf;
            exp_rf = (cyc - init_cyc) / REF_INTERVAL;
            check(rf_count >= exp_rf - 1 && rf_count <= exp_rf + 1, "R8 average refresh rate", rf_count, exp_rf);
        end
        finish_run();
    end

endmodule